// File: doc/BRIEF.md
# Block-RAM Table Scan Matcher

This block decides whether a 32-bit key is present in a table of 32-bit values held in on-chip block RAM. If it is, the block reports where. Keys arrive on a ready/valid stream. A processor-side write port loads the table while the engine is idle. A lookup walks the table one RAM word per clock per bank. The key is compared with each word as it comes out of the RAM, and the walk stops at the first match.

The table of `ENTRIES` words is interleaved across `NUM_BANKS` banks. Global entry g lives in bank g mod `NUM_BANKS`, at local word g / `NUM_BANKS`. All banks are read at the same local address in the same cycle. A lookup therefore needs about `ENTRIES / NUM_BANKS` clocks rather than `ENTRIES`, and the first hit in time is also the lowest matching global index.

The default is 2048 entries in eight banks of 256 words. Both parameters must be powers of two. Each result comes with a one-cycle done pulse. The hit flag and the index are registered, and they hold until the next result.

Top module: `tbl_scan_match`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs are: `key_ready_o`=1 (with `wr_en_i` low), `busy_o`=0, `done_o`=0, `hit_o`=0 and `hit_idx_o`=0. A reset during a lookup abandons the lookup.
- R2: A key is taken on a rising edge where `key_valid_i` and `key_ready_o` are both high. `busy_o` is high from that edge until the cycle that carries `done_o`, and `key_ready_o` is low throughout. `key_ready_o` is also low in any cycle with `wr_en_i` high, so a write wins over a key in the same cycle.
- R3: When `wr_en_i` is high and `busy_o` is low on a rising edge, `wr_data_i` is stored as entry `wr_addr_i`. Lookups that start later see the new value.
- R4: A write attempted while `busy_o` is high is dropped, and the table is unchanged.
- R5: On a hit, `done_o` is high for exactly one cycle, with `hit_o`=1 and `hit_idx_o` equal to the global index of the matching entry, zero-extended to 32 bits.
- R6: When several entries match, the lowest global index is reported. This holds both for matches in the same local word of different banks and for matches in different local words.
- R7: On a miss, `done_o` is high for one cycle with `hit_o`=0 and `hit_idx_o`=0.
- R8: `done_o` rises L+2 clocks after the accepting edge, where L is the local word index (g / `NUM_BANKS`) of the reported hit. On a miss it rises `ENTRIES/NUM_BANKS`+1 clocks after the accepting edge.
- R9: `hit_o` and `hit_idx_o` change only in a cycle where `done_o` is high. Otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | $clog2(ENTRIES) | Global entry index to write |
| wr_data_i | input | 32 | Value to store |
| busy_o | output | 1 | Lookup in progress; writes are dropped |
| key_valid_i | input | 1 | Key offered |
| key_ready_o | output | 1 | Key can be taken this cycle |
| key_i | input | 32 | Key to search for |
| done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | Last lookup found the key |
| hit_idx_o | output | 32 | Global index of the match, zero on a miss |

## Verification
The hardest cases to reach from the ports are two. One is a write that lands in the middle of a scan. The other is two matches falling in the same RAM word slot of different banks. For the first, the bench starts a lookup of a missing key, pulses a write a few cycles into the busy window, then looks up the written value and expects a miss. For the second, it plants equal values at entries that share a local word, then at entries one word apart in the reverse bank order. It checks both the reported index and the done latency.

// File: rtl/tbl_scan_pkg.sv
package tbl_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_LAST = 2'd2
  } scan_st_e;

  localparam int unsigned KEY_W = 32;

  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tbl_scan_bank.sv
module tbl_scan_bank #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned LAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           we_i,
  input  logic [LAW-1:0] waddr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           re_i,
  input  logic [LAW-1:0] raddr_i,
  input  logic [W-1:0]   key_i,
  input  logic           cmp_v_i,
  output logic           hit_o
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  // plain RAM, no reset on storage
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem[raddr_i];
  end

  assign hit_o = cmp_v_i && (rd_q == key_i);

endmodule

// File: rtl/tbl_scan_pick.sv
module tbl_scan_pick #(
  parameter int unsigned NB  = 8,
  localparam int unsigned SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0] hit_i,
  output logic          any_o,
  output logic [SW-1:0] sel_o
);

  // lowest bank wins
  always_comb begin
    sel_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = SW'(i);
    end
  end

  assign any_o = |hit_i;

endmodule

// File: rtl/tbl_scan_ctrl.sv
module tbl_scan_ctrl
  import tbl_scan_pkg::*;
#(
  parameter int unsigned BANK_DEPTH = 256,
  parameter int unsigned NB         = 8,
  localparam int unsigned LAW       = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1,
  localparam int unsigned SW        = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             wr_en_i,
  output logic             key_ready_o,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic [LAW-1:0]   rd_addr_o,
  output logic [KEY_W-1:0] key_q_o,
  output logic             cmp_v_o,
  input  logic             any_hit_i,
  input  logic [SW-1:0]    sel_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [31:0]      hit_idx_o
);

  localparam logic [LAW-1:0] LAST_ADDR = LAW'(BANK_DEPTH - 1);

  scan_st_e       st_q;
  logic [LAW-1:0] cnt_q;
  logic [LAW-1:0] cmp_addr_q;
  logic           cmp_v_q;
  logic           cmp_last_q;
  logic           key_fire;
  logic           resolve;
  logic [31:0]    gidx;

  assign key_ready_o = (st_q == ST_IDLE) && !wr_en_i;
  assign busy_o      = (st_q != ST_IDLE);
  assign key_fire    = key_valid_i && key_ready_o;
  assign rd_en_o     = (st_q == ST_SCAN);
  assign rd_addr_o   = cnt_q;
  assign cmp_v_o     = cmp_v_q;
  assign resolve     = cmp_v_q && (any_hit_i || cmp_last_q);
  assign gidx        = 32'(cmp_addr_q) * 32'(NB) + 32'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      cmp_addr_q <= '0;
      cmp_v_q    <= 1'b0;
      cmp_last_q <= 1'b0;
      key_q_o    <= '0;
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      hit_idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (resolve) begin
        done_o    <= 1'b1;
        hit_o     <= any_hit_i;
        hit_idx_o <= any_hit_i ? gidx : 32'd0;
      end
      unique case (st_q)
        ST_IDLE: begin
          cmp_v_q    <= 1'b0;
          cmp_last_q <= 1'b0;
          if (key_fire) begin
            st_q    <= ST_SCAN;
            cnt_q   <= '0;
            key_q_o <= key_i;
          end
        end
        ST_SCAN: begin
          if (resolve) begin
            // early stop, flush word in flight
            st_q    <= ST_IDLE;
            cmp_v_q <= 1'b0;
          end else begin
            cmp_v_q    <= 1'b1;
            cmp_addr_q <= cnt_q;
            cmp_last_q <= (cnt_q == LAST_ADDR);
            cnt_q      <= cnt_q + 1'b1;
            if (cnt_q == LAST_ADDR) st_q <= ST_LAST;
          end
        end
        ST_LAST: begin
          st_q       <= ST_IDLE;
          cmp_v_q    <= 1'b0;
          cmp_last_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tbl_scan_match.sv
module tbl_scan_match
  import tbl_scan_pkg::*;
#(
  parameter int unsigned ENTRIES   = 2048,
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned AW       = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic             busy_o,
  input  logic             key_valid_i,
  output logic             key_ready_o,
  input  logic [KEY_W-1:0] key_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [31:0]      hit_idx_o
);

  localparam int unsigned BANK_DEPTH = ENTRIES / NUM_BANKS;
  localparam int unsigned LAW = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int unsigned SW  = sel_width(NUM_BANKS);

  logic [LAW-1:0]       wr_local;
  logic [SW-1:0]        wr_bank;
  logic                 wr_ok;
  logic [NUM_BANKS-1:0] bank_we;
  logic [NUM_BANKS-1:0] bank_hit;
  logic                 rd_en;
  logic [LAW-1:0]       rd_addr;
  logic [KEY_W-1:0]     key_q;
  logic                 cmp_v;
  logic                 any_hit;
  logic [SW-1:0]        hit_sel;

  assign wr_ok = wr_en_i && !busy_o;

  // entry g -> bank g mod NUM_BANKS, word g / NUM_BANKS
  if (NUM_BANKS == 1) begin : g_addr_one
    assign wr_local = wr_addr_i;
    assign wr_bank  = '0;
  end else begin : g_addr_split
    assign wr_local = wr_addr_i[AW-1:SW];
    assign wr_bank  = wr_addr_i[SW-1:0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_ok && (wr_bank == SW'(b));
    tbl_scan_bank #(
      .W    (KEY_W),
      .DEPTH(BANK_DEPTH)
    ) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[b]),
      .waddr_i(wr_local),
      .wdata_i(wr_data_i),
      .re_i   (rd_en),
      .raddr_i(rd_addr),
      .key_i  (key_q),
      .cmp_v_i(cmp_v),
      .hit_o  (bank_hit[b])
    );
  end

  tbl_scan_pick #(.NB(NUM_BANKS)) u_pick (
    .hit_i(bank_hit),
    .any_o(any_hit),
    .sel_o(hit_sel)
  );

  tbl_scan_ctrl #(
    .BANK_DEPTH(BANK_DEPTH),
    .NB        (NUM_BANKS)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_valid_i(key_valid_i),
    .key_i      (key_i),
    .wr_en_i    (wr_en_i),
    .key_ready_o(key_ready_o),
    .busy_o     (busy_o),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .key_q_o    (key_q),
    .cmp_v_o    (cmp_v),
    .any_hit_i  (any_hit),
    .sel_i      (hit_sel),
    .done_o     (done_o),
    .hit_o      (hit_o),
    .hit_idx_o  (hit_idx_o)
  );

endmodule

// File: rtl/tbl_scan_match_chk.sv
module tbl_scan_match_chk #(
  parameter int unsigned ENTRIES = 2048
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        busy_o,
  input logic        key_valid_i,
  input logic        key_ready_o,
  input logic        done_o,
  input logic        hit_o,
  input logic [31:0] hit_idx_o
);

  p_ready_off_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !key_ready_o);

  p_write_no_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !key_ready_o);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> busy_o);

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (hit_idx_o < ENTRIES));

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (hit_idx_o == 32'd0));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_hold_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hit_o) && $stable(hit_idx_o)));

endmodule

bind tbl_scan_match tbl_scan_match_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .busy_o     (busy_o),
  .key_valid_i(key_valid_i),
  .key_ready_o(key_ready_o),
  .done_o     (done_o),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o)
);

// File: tb/tbl_scan_match_tb.sv
module tbl_scan_match_tb;

  localparam int unsigned ENTRIES = 64;
  localparam int unsigned NB      = 4;
  localparam int unsigned BD      = ENTRIES / NB;
  localparam int unsigned AW      = $clog2(ENTRIES);
  localparam int unsigned NV      = 9;

  // {key, expect hit, expect index}
  localparam logic [64:0] VEC [NV] = '{
    {32'hA500_0000, 1'b1, 32'd0},
    {32'hA500_3F3F, 1'b1, 32'd63},
    {32'hA500_0505, 1'b1, 32'd5},
    {32'hA500_1111, 1'b1, 32'd17},
    {32'hA500_2020, 1'b1, 32'd32},
    {32'hDEAD_BEEF, 1'b0, 32'd0},
    {32'hA500_0101, 1'b1, 32'd1},
    {32'hA500_2F2F, 1'b1, 32'd47},
    {32'hA500_0001, 1'b0, 32'd0}
  };

  localparam logic [31:0] K_MISS = 32'hDEAD_BEEF;
  localparam logic [31:0] K_X    = 32'h1234_5678;
  localparam logic [31:0] K_D    = 32'h0BAD_F00D;
  localparam logic [31:0] K_E    = 32'h0C0F_FEE0;
  localparam logic [31:0] K_F    = 32'h0FAC_ADE0;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          busy_o;
  logic          key_valid_i = 1'b0;
  logic          key_ready_o;
  logic [31:0]   key_i = '0;
  logic          done_o;
  logic          hit_o;
  logic [31:0]   hit_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tbl_scan_match #(.ENTRIES(ENTRIES), .NUM_BANKS(NB)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .busy_o     (busy_o),
    .key_valid_i(key_valid_i),
    .key_ready_o(key_ready_o),
    .key_i      (key_i),
    .done_o     (done_o),
    .hit_o      (hit_o),
    .hit_idx_o  (hit_idx_o)
  );

  function automatic logic [31:0] fill_val(int g);
    return 32'hA500_0000 + 32'(g) * 32'h101;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
  endtask

  task automatic write_entry(int g, logic [31:0] v);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_addr_i = AW'(g);
    wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done_o && lat < 1000);
  endtask

  task automatic lookup(input logic [31:0] k, output logic h,
                        output logic [31:0] ix, output int lat);
    @(negedge clk);
    key_i       = k;
    key_valid_i = 1'b1;
    @(negedge clk);
    key_valid_i = 1'b0;
    wait_done(lat);
    h  = hit_o;
    ix = hit_idx_o;
  endtask

  function automatic int exp_lat(logic h, logic [31:0] ix);
    return h ? int'(ix) / NB + 2 : BD + 1;
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic        h;
    logic [31:0] ix;
    int          lat;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(key_ready_o), 32'd1);
    check("R1 busy in reset", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 done after reset", 32'(done_o), 32'd0);
    check("R1 hit after reset", 32'(hit_o), 32'd0);
    check("R1 idx after reset", hit_idx_o, 32'd0);
    check("R1 ready after reset", 32'(key_ready_o), 32'd1);

    // R3 fill table
    for (int g = 0; g < ENTRIES; g++) write_entry(g, fill_val(g));

    // R5 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      lookup(VEC[v][64:33], h, ix, lat);
      if (VEC[v][32]) begin
        check("R5 hit flag", 32'(h), 32'd1);
        check("R5 hit index", ix, VEC[v][31:0]);
      end else begin
        check("R7 miss flag", 32'(h), 32'd0);
        check("R7 miss index", ix, 32'd0);
      end
      check("R8 latency", 32'(lat), 32'(exp_lat(VEC[v][32], VEC[v][31:0])));
      @(negedge clk);
      check("R5 done one cycle", 32'(done_o), 32'd0);
    end

    // R9 result holds while idle
    lookup(fill_val(22), h, ix, lat);
    repeat (5) @(negedge clk);
    check("R9 hit held", 32'(hit_o), 32'd1);
    check("R9 idx held", hit_idx_o, 32'd22);

    // R2 write beats key in same cycle
    @(negedge clk);
    wr_en_i     = 1'b1;
    wr_addr_i   = AW'(63);
    wr_data_i   = fill_val(63);
    key_i       = fill_val(3);
    key_valid_i = 1'b1;
    #1;
    check("R2 ready low on write", 32'(key_ready_o), 32'd0);
    @(negedge clk);
    wr_en_i     = 1'b0;
    key_valid_i = 1'b0;
    check("R2 key not taken on write", 32'(busy_o), 32'd0);

    // R4 write during scan dropped
    @(negedge clk);
    key_i       = K_MISS;
    key_valid_i = 1'b1;
    @(negedge clk);
    key_valid_i = 1'b0;
    @(negedge clk);
    check("R2 busy during scan", 32'(busy_o), 32'd1);
    check("R2 ready low during scan", 32'(key_ready_o), 32'd0);
    wr_en_i   = 1'b1;
    wr_addr_i = AW'(40);
    wr_data_i = K_X;
    @(negedge clk);
    wr_en_i = 1'b0;
    wait_done(lat);
    check("R7 miss while writing", 32'(hit_o), 32'd0);
    lookup(K_X, h, ix, lat);
    check("R4 dropped write flag", 32'(h), 32'd0);
    lookup(fill_val(40), h, ix, lat);
    check("R4 old entry kept", ix, 32'd40);

    // R3 idle write visible
    write_entry(40, K_X);
    lookup(K_X, h, ix, lat);
    check("R3 new entry hit", 32'(h), 32'd1);
    check("R3 new entry index", ix, 32'd40);
    check("R8 latency entry 40", 32'(lat), 32'd12);

    // R6 same local word, banks 1 and 2
    write_entry(6, K_D);
    write_entry(5, K_D);
    lookup(K_D, h, ix, lat);
    check("R6 same word lowest bank", ix, 32'd5);
    check("R8 latency same word", 32'(lat), 32'd3);
    // R6 earlier word in higher bank
    write_entry(12, K_E);
    write_entry(9, K_E);
    lookup(K_E, h, ix, lat);
    check("R6 earlier word wins", ix, 32'd9);
    // R6 banks 3 and 0 same word
    write_entry(7, K_F);
    write_entry(4, K_F);
    lookup(K_F, h, ix, lat);
    check("R6 bank0 over bank3", ix, 32'd4);

    // R1 reset mid-scan
    @(negedge clk);
    key_i       = K_MISS;
    key_valid_i = 1'b1;
    @(negedge clk);
    key_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 busy cleared", 32'(busy_o), 32'd0);
    check("R1 hit cleared", 32'(hit_o), 32'd0);
    check("R1 idx cleared", hit_idx_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready after mid reset", 32'(key_ready_o), 32'd1);
    lookup(fill_val(20), h, ix, lat);
    check("R1 table kept over reset", ix, 32'd20);

    summary();
    $finish;
  end

endmodule